// File: doc/BRIEF.md
# DMA Doorbell and Interrupt Controller

This block is the control front end of a small DMA engine that moves data in two directions: a write direction with four channels and a read direction with two. Host software reaches it over a plain 32-bit register bus. For each direction it holds an engine enable, a doorbell that starts or stops one channel, a combined status register (completion flags in the low half, abort flags from bit 16 up), a matching mask register and a write-one-to-clear register. It also holds the target addresses and per-channel data values used to signal completion to the host by a memory-write interrupt message.

The data movers report back with one-cycle done and abort pulses per channel. The controller tracks which channels are busy, records status, and whenever an unmasked status flag goes from clear to set it queues one interrupt message. A fixed-priority arbiter sends the queued messages one at a time over a request/acknowledge pair. A write with the stop bit set ends a running channel early and records it as an abort. Data movement and descriptor handling lie outside this block.

Top module: `dma_dbirq_ctrl`

## Requirements
- R1: The write direction has 4 channels (0..3) and the read direction 2 (0..1); a doorbell whose channel field (bits 7:0) names a channel at or beyond that count changes no busy flag, status bit or start/stop output.
- R2: Each direction has an enable register (write 0x0C, read 0x2C) whose bit 0 resets to 0; while it is 0 every doorbell write for that direction is ignored.
- R3: A doorbell write (write 0x10, read 0x30) with bit 31 clear to an idle channel sets that channel's busy output and raises its start output for exactly one cycle, both visible after the write's clock edge; the same write to a channel that is already busy does nothing.
- R4: A doorbell write with bit 31 set to a busy channel clears its busy output, raises its stop output for one cycle and sets abort status bit 16+n; to an idle channel it has no effect.
- R5: A done pulse on a busy channel n clears busy and sets status bit n; an abort pulse on a busy channel clears busy and sets bit 16+n; pulses on idle channels are ignored. Status is at write 0x4C, read 0xA0.
- R6: Writing the clear register (write 0x58, read 0xAC) clears each status bit whose written bit is 1 and leaves bits written 0 unchanged.
- R7: A mask register (write 0x54, read 0xA8, same bit layout as status, reset 0) with a bit at 1 suppresses the message for that source while the status bit still sets.
- R8: When an unmasked status bit goes from 0 to 1 exactly one message is raised: the request stays high with stable address and data until a one-cycle acknowledge; the address is the direction's 64-bit done or abort address (done low/high at write 0x60/0x64, read 0xCC/0xD0; abort low/high at write 0x68/0x6C, read 0xD4/0xD8) and the data is the channel's 16-bit value, held in the word at base+4*(n/2) (write base 0x70, read base 0xDC), bits 15:0 for even n and 31:16 for odd n. An event that finds its status bit already set sends nothing.
- R9: Only one message is outstanding; pending messages go out in fixed order: write done (channel 0 first), write abort, read done, read abort.
- R10: After reset all status, mask, enable and busy state reads 0 and no message is requested.
- R11: Enable, status, mask, address and data registers read back their contents; the doorbell and clear registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW (12) | Byte address of the register, word aligned |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| wr_done_i | input | WR_CH (4) | Write-direction channel completion pulses |
| wr_abort_i | input | WR_CH (4) | Write-direction channel error pulses |
| wr_start_o | output | WR_CH (4) | One-cycle start command per write channel |
| wr_stop_o | output | WR_CH (4) | One-cycle stop command per write channel |
| wr_busy_o | output | WR_CH (4) | Write channel running |
| rd_done_i | input | RD_CH (2) | Read-direction channel completion pulses |
| rd_abort_i | input | RD_CH (2) | Read-direction channel error pulses |
| rd_start_o | output | RD_CH (2) | One-cycle start command per read channel |
| rd_stop_o | output | RD_CH (2) | One-cycle stop command per read channel |
| rd_busy_o | output | RD_CH (2) | Read channel running |
| msg_req_o | output | 1 | Interrupt message request |
| msg_ack_i | input | 1 | One-cycle acceptance of the message |
| msg_addr_o | output | 64 | Message target address |
| msg_data_o | output | 16 | Message data value |

## Verification
The assertions assume that the acknowledge only arrives while a request is up, that a channel never sees a done and an abort pulse in the same cycle, and that register writes are word aligned. The bench keeps within this by raising acknowledge only after it has seen the request at a falling edge and dropping it one cycle later, by pulsing at most one kind of completion per channel at a time, and by addressing registers only at multiples of four. Within those limits it sweeps every channel of both directions through start, repeated start, completion, stop, idle stop and clearing, then probes out-of-range channel numbers, masking and a four-way simultaneous completion for message order.

// File: rtl/dma_dbirq_pkg.sv
package dma_dbirq_pkg;

   // Register bus
   localparam int REG_AW     = 12;
   localparam int CH_SEL_W   = 8;   // channel field in the doorbell word
   localparam int STOP_BIT   = 31;  // doorbell stop request
   localparam int ABORT_LSB  = 16;  // abort flags start here in status/mask/clear
   localparam int MAX_CH     = 16;  // limited by ABORT_LSB

   // Write-direction map
   localparam int W_EN_OFF   = 'h0C;
   localparam int W_DB_OFF   = 'h10;
   localparam int W_ST_OFF   = 'h4C;
   localparam int W_MSK_OFF  = 'h54;
   localparam int W_CLR_OFF  = 'h58;
   localparam int W_DLO_OFF  = 'h60;
   localparam int W_DHI_OFF  = 'h64;
   localparam int W_ALO_OFF  = 'h68;
   localparam int W_AHI_OFF  = 'h6C;
   localparam int W_DAT_OFF  = 'h70;

   // Read-direction map
   localparam int R_EN_OFF   = 'h2C;
   localparam int R_DB_OFF   = 'h30;
   localparam int R_ST_OFF   = 'hA0;
   localparam int R_MSK_OFF  = 'hA8;
   localparam int R_CLR_OFF  = 'hAC;
   localparam int R_DLO_OFF  = 'hCC;
   localparam int R_DHI_OFF  = 'hD0;
   localparam int R_ALO_OFF  = 'hD4;
   localparam int R_AHI_OFF  = 'hD8;
   localparam int R_DAT_OFF  = 'hDC;

endpackage

// File: rtl/dma_dir_regs.sv
module dma_dir_regs
   import dma_dbirq_pkg::*;
#(
   parameter int NCH     = 4,
   parameter int AW      = REG_AW,
   parameter int EN_OFF  = W_EN_OFF,
   parameter int DB_OFF  = W_DB_OFF,
   parameter int ST_OFF  = W_ST_OFF,
   parameter int MSK_OFF = W_MSK_OFF,
   parameter int CLR_OFF = W_CLR_OFF,
   parameter int DLO_OFF = W_DLO_OFF,
   parameter int DHI_OFF = W_DHI_OFF,
   parameter int ALO_OFF = W_ALO_OFF,
   parameter int AHI_OFF = W_AHI_OFF,
   parameter int DAT_OFF = W_DAT_OFF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr_i,
   input  logic [AW-1:0]       reg_addr_i,
   input  logic [31:0]         reg_wdata_i,
   input  logic [NCH-1:0]      done_i,
   input  logic [NCH-1:0]      abort_i,
   input  logic [2*NCH-1:0]    pend_clr_i,
   output logic                hit_o,
   output logic [31:0]         rdata_o,
   output logic [NCH-1:0]      start_o,
   output logic [NCH-1:0]      stop_o,
   output logic [NCH-1:0]      busy_o,
   output logic [2*NCH-1:0]    pend_o,
   output logic [63:0]         done_addr_o,
   output logic [63:0]         abort_addr_o,
   output logic [16*NCH-1:0]   msg_data_o
);

   localparam int DW = (NCH + 1) / 2;   // data words holding two channel values each

   if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
      $error("dma_dir_regs: NCH out of range");
   end

   logic              en_q;
   logic [NCH-1:0]    busy_q, start_q, stop_q;
   logic [NCH-1:0]    sdone_q, sabt_q, mdone_q, mabt_q, pdone_q, pabt_q;
   logic [31:0]       dlo_q, dhi_q, alo_q, ahi_q;
   wire  [16*NCH-1:0] dat_all;
   logic [32*DW-1:0]  dat_pad;

   logic              wr_db, wr_clr, db_stop, db_ok;
   logic [CH_SEL_W-1:0] db_ch;
   logic [NCH-1:0]    go, halt, fin_d, fin_a, busy_d;
   logic [NCH-1:0]    sdone_d, sabt_d, pdone_d, pabt_d;

   // ---------------- doorbell, status and pending logic ----------------
   always_comb begin
      wr_db   = reg_wr_i && (reg_addr_i == AW'(DB_OFF));
      wr_clr  = reg_wr_i && (reg_addr_i == AW'(CLR_OFF));
      db_ch   = reg_wdata_i[CH_SEL_W-1:0];
      db_stop = reg_wdata_i[STOP_BIT];
      db_ok   = wr_db && en_q && (int'(db_ch) < NCH);
      for (int n = 0; n < NCH; n++) begin
         logic hitn;
         hitn       = db_ok && (int'(db_ch) == n);
         go[n]      = hitn && !db_stop && !busy_q[n];
         halt[n]    = hitn && db_stop && busy_q[n] && !done_i[n];
         fin_d[n]   = busy_q[n] && done_i[n];
         fin_a[n]   = busy_q[n] && !done_i[n] && (abort_i[n] || (hitn && db_stop));
         busy_d[n]  = go[n] || (busy_q[n] && !fin_d[n] && !fin_a[n]);
         sdone_d[n] = fin_d[n] || (sdone_q[n] && !(wr_clr && reg_wdata_i[n]));
         sabt_d[n]  = fin_a[n] || (sabt_q[n] && !(wr_clr && reg_wdata_i[ABORT_LSB+n]));
         pdone_d[n] = (fin_d[n] && !sdone_q[n] && !mdone_q[n]) ||
                      (pdone_q[n] && !pend_clr_i[n]);
         pabt_d[n]  = (fin_a[n] && !sabt_q[n] && !mabt_q[n]) ||
                      (pabt_q[n] && !pend_clr_i[NCH+n]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         busy_q  <= '0;
         start_q <= '0;
         stop_q  <= '0;
         sdone_q <= '0;
         sabt_q  <= '0;
         mdone_q <= '0;
         mabt_q  <= '0;
         pdone_q <= '0;
         pabt_q  <= '0;
         dlo_q   <= '0;
         dhi_q   <= '0;
         alo_q   <= '0;
         ahi_q   <= '0;
      end else begin
         busy_q  <= busy_d;
         start_q <= go;
         stop_q  <= halt;
         sdone_q <= sdone_d;
         sabt_q  <= sabt_d;
         pdone_q <= pdone_d;
         pabt_q  <= pabt_d;
         if (reg_wr_i) begin
            if (reg_addr_i == AW'(EN_OFF))  en_q  <= reg_wdata_i[0];
            if (reg_addr_i == AW'(DLO_OFF)) dlo_q <= reg_wdata_i;
            if (reg_addr_i == AW'(DHI_OFF)) dhi_q <= reg_wdata_i;
            if (reg_addr_i == AW'(ALO_OFF)) alo_q <= reg_wdata_i;
            if (reg_addr_i == AW'(AHI_OFF)) ahi_q <= reg_wdata_i;
            if (reg_addr_i == AW'(MSK_OFF)) begin
               mdone_q <= reg_wdata_i[NCH-1:0];
               mabt_q  <= reg_wdata_i[ABORT_LSB +: NCH];
            end
         end
      end
   end

   // ---------------- per-channel message data halves ----------------
   for (genvar n = 0; n < NCH; n++) begin : g_dat
      localparam int HALF = n % 2;
      localparam int WOFF = DAT_OFF + 4 * (n / 2);
      logic [15:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            val_q <= '0;
         else if (reg_wr_i && (reg_addr_i == AW'(WOFF)))
            val_q <= reg_wdata_i[16*HALF +: 16];
      end
      assign dat_all[16*n +: 16] = val_q;
   end

   always_comb begin
      dat_pad = '0;
      dat_pad[16*NCH-1:0] = dat_all;
   end

   // ---------------- read mux ----------------
   always_comb begin
      hit_o   = 1'b1;
      rdata_o = '0;
      if (reg_addr_i == AW'(EN_OFF))
         rdata_o[0] = en_q;
      else if (reg_addr_i == AW'(ST_OFF)) begin
         rdata_o[NCH-1:0]          = sdone_q;
         rdata_o[ABORT_LSB +: NCH] = sabt_q;
      end else if (reg_addr_i == AW'(MSK_OFF)) begin
         rdata_o[NCH-1:0]          = mdone_q;
         rdata_o[ABORT_LSB +: NCH] = mabt_q;
      end else if (reg_addr_i == AW'(DB_OFF) || reg_addr_i == AW'(CLR_OFF))
         rdata_o = '0;
      else if (reg_addr_i == AW'(DLO_OFF)) rdata_o = dlo_q;
      else if (reg_addr_i == AW'(DHI_OFF)) rdata_o = dhi_q;
      else if (reg_addr_i == AW'(ALO_OFF)) rdata_o = alo_q;
      else if (reg_addr_i == AW'(AHI_OFF)) rdata_o = ahi_q;
      else begin
         hit_o = 1'b0;
         for (int w = 0; w < DW; w++) begin
            if (reg_addr_i == AW'(DAT_OFF + 4 * w)) begin
               hit_o   = 1'b1;
               rdata_o = dat_pad[32*w +: 32];
            end
         end
      end
   end

   assign start_o      = start_q;
   assign stop_o       = stop_q;
   assign busy_o       = busy_q;
   assign pend_o       = {pabt_q, pdone_q};
   assign done_addr_o  = {dhi_q, dlo_q};
   assign abort_addr_o = {ahi_q, alo_q};
   assign msg_data_o   = dat_all;

   // ---------------- assertions ----------------
   for (genvar n = 0; n < NCH; n++) begin : g_chk
      p_start_from_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
         start_o[n] |-> (busy_o[n] && !$past(busy_o[n])));
      p_busy_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(busy_o[n]) |-> $past(en_q));
      p_stop_aborts_r4: assert property (@(posedge clk) disable iff (!rst_n)
         stop_o[n] |-> (sabt_q[n] && !busy_o[n]));
      p_done_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (busy_o[n] && done_i[n]) |=> (!busy_o[n] && sdone_q[n]));
      p_done_abort_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !(done_i[n] && abort_i[n]));
      p_mask_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pdone_q[n]) |-> !$past(mdone_q[n]));
   end

endmodule

// File: rtl/dma_msg_arb.sv
module dma_msg_arb #(
   parameter int NSRC = 12,
   localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  pend_i,
   input  logic             ack_i,
   output logic             req_o,
   output logic [IDXW-1:0]  idx_o,
   output logic [NSRC-1:0]  clr_o
);

   if (NSRC < 2) begin : g_bad_nsrc
      $error("dma_msg_arb: need at least two sources");
   end

   logic [IDXW-1:0] nxt;
   logic            req_q;
   logic [IDXW-1:0] idx_q;

   // lowest index wins
   always_comb begin
      nxt = '0;
      for (int i = NSRC - 1; i >= 0; i--)
         if (pend_i[i]) nxt = IDXW'(i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         idx_q <= '0;
      end else if (req_q && ack_i) begin
         req_q <= 1'b0;
      end else if (!req_q && (|pend_i)) begin
         req_q <= 1'b1;
         idx_q <= nxt;
      end
   end

   always_comb begin
      for (int i = 0; i < NSRC; i++)
         clr_o[i] = req_q && ack_i && (int'(idx_q) == i);
   end

   assign req_o = req_q;
   assign idx_o = idx_q;

   p_ack_in_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |-> req_o);
   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ack_i) |=> (req_o && $stable(idx_o)));
   p_req_backed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> pend_i[idx_o]);
   p_single_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_o));

endmodule

// File: rtl/dma_dbirq_ctrl.sv
module dma_dbirq_ctrl
   import dma_dbirq_pkg::*;
#(
   parameter int WR_CH = 4,
   parameter int RD_CH = 2,
   parameter int AW    = REG_AW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_i,
   input  logic [AW-1:0]    reg_addr_i,
   input  logic [31:0]      reg_wdata_i,
   output logic [31:0]      reg_rdata_o,
   input  logic [WR_CH-1:0] wr_done_i,
   input  logic [WR_CH-1:0] wr_abort_i,
   output logic [WR_CH-1:0] wr_start_o,
   output logic [WR_CH-1:0] wr_stop_o,
   output logic [WR_CH-1:0] wr_busy_o,
   input  logic [RD_CH-1:0] rd_done_i,
   input  logic [RD_CH-1:0] rd_abort_i,
   output logic [RD_CH-1:0] rd_start_o,
   output logic [RD_CH-1:0] rd_stop_o,
   output logic [RD_CH-1:0] rd_busy_o,
   output logic             msg_req_o,
   input  logic             msg_ack_i,
   output logic [63:0]      msg_addr_o,
   output logic [15:0]      msg_data_o
);

   localparam int WSRC = 2 * WR_CH;
   localparam int RSRC = 2 * RD_CH;
   localparam int NSRC = WSRC + RSRC;
   localparam int IDXW = $clog2(NSRC);

   if (WR_CH < 1 || WR_CH > MAX_CH || RD_CH < 1 || RD_CH > MAX_CH) begin : g_bad_cfg
      $error("dma_dbirq_ctrl: channel count out of range");
   end
   if (AW < 8) begin : g_bad_aw
      $error("dma_dbirq_ctrl: address too narrow for register map");
   end

   logic              wr_hit, rd_hit;
   logic [31:0]       wr_rdata, rd_rdata;
   logic [WSRC-1:0]   wr_pend;
   logic [RSRC-1:0]   rd_pend;
   logic [NSRC-1:0]   clr;
   logic [63:0]       wr_dadr, wr_aadr, rd_dadr, rd_aadr;
   logic [16*WR_CH-1:0] wr_dat;
   logic [16*RD_CH-1:0] rd_dat;
   logic [IDXW-1:0]   idx;

   dma_dir_regs #(
      .NCH(WR_CH), .AW(AW),
      .EN_OFF(W_EN_OFF), .DB_OFF(W_DB_OFF), .ST_OFF(W_ST_OFF),
      .MSK_OFF(W_MSK_OFF), .CLR_OFF(W_CLR_OFF),
      .DLO_OFF(W_DLO_OFF), .DHI_OFF(W_DHI_OFF),
      .ALO_OFF(W_ALO_OFF), .AHI_OFF(W_AHI_OFF), .DAT_OFF(W_DAT_OFF)
   ) wr_dir_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
      .done_i(wr_done_i), .abort_i(wr_abort_i), .pend_clr_i(clr[WSRC-1:0]),
      .hit_o(wr_hit), .rdata_o(wr_rdata),
      .start_o(wr_start_o), .stop_o(wr_stop_o), .busy_o(wr_busy_o),
      .pend_o(wr_pend), .done_addr_o(wr_dadr), .abort_addr_o(wr_aadr),
      .msg_data_o(wr_dat)
   );

   dma_dir_regs #(
      .NCH(RD_CH), .AW(AW),
      .EN_OFF(R_EN_OFF), .DB_OFF(R_DB_OFF), .ST_OFF(R_ST_OFF),
      .MSK_OFF(R_MSK_OFF), .CLR_OFF(R_CLR_OFF),
      .DLO_OFF(R_DLO_OFF), .DHI_OFF(R_DHI_OFF),
      .ALO_OFF(R_ALO_OFF), .AHI_OFF(R_AHI_OFF), .DAT_OFF(R_DAT_OFF)
   ) rd_dir_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
      .done_i(rd_done_i), .abort_i(rd_abort_i), .pend_clr_i(clr[NSRC-1:WSRC]),
      .hit_o(rd_hit), .rdata_o(rd_rdata),
      .start_o(rd_start_o), .stop_o(rd_stop_o), .busy_o(rd_busy_o),
      .pend_o(rd_pend), .done_addr_o(rd_dadr), .abort_addr_o(rd_aadr),
      .msg_data_o(rd_dat)
   );

   // source order sets priority: write done, write abort, read done, read abort
   dma_msg_arb #(.NSRC(NSRC)) arb_i (
      .clk(clk), .rst_n(rst_n),
      .pend_i({rd_pend, wr_pend}), .ack_i(msg_ack_i),
      .req_o(msg_req_o), .idx_o(idx), .clr_o(clr)
   );

   always_comb begin
      int k;
      k = int'(idx);
      if (k < WR_CH) begin
         msg_addr_o = wr_dadr;
         msg_data_o = wr_dat[16*k +: 16];
      end else if (k < WSRC) begin
         msg_addr_o = wr_aadr;
         msg_data_o = wr_dat[16*(k-WR_CH) +: 16];
      end else if (k < WSRC + RD_CH) begin
         msg_addr_o = rd_dadr;
         msg_data_o = rd_dat[16*(k-WSRC) +: 16];
      end else begin
         msg_addr_o = rd_aadr;
         msg_data_o = rd_dat[16*(k-WSRC-RD_CH) +: 16];
      end
   end

   always_comb begin
      if (wr_hit)      reg_rdata_o = wr_rdata;
      else if (rd_hit) reg_rdata_o = rd_rdata;
      else             reg_rdata_o = '0;
   end

   p_idle_after_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_req_o) |-> $past(|{rd_pend, wr_pend}));
   p_map_disjoint_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_hit && rd_hit));

endmodule

// File: tb/dma_dbirq_ctrl_tb_top.sv
module dma_dbirq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WR_N = 4;
   localparam int RD_N = 2;
   localparam logic [31:0] STOP = 32'h8000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [WR_N-1:0] wr_done = '0, wr_abort = '0;
   logic [WR_N-1:0] wr_start, wr_stop, wr_busy;
   logic [RD_N-1:0] rd_done = '0, rd_abort = '0;
   logic [RD_N-1:0] rd_start, rd_stop, rd_busy;
   logic        msg_req;
   logic        msg_ack = 1'b0;
   logic [63:0] msg_addr;
   logic [15:0] msg_data;

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_dbirq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
      .reg_rdata_o(reg_rdata),
      .wr_done_i(wr_done), .wr_abort_i(wr_abort),
      .wr_start_o(wr_start), .wr_stop_o(wr_stop), .wr_busy_o(wr_busy),
      .rd_done_i(rd_done), .rd_abort_i(rd_abort),
      .rd_start_o(rd_start), .rd_stop_o(rd_stop), .rd_busy_o(rd_busy),
      .msg_req_o(msg_req), .msg_ack_i(msg_ack),
      .msg_addr_o(msg_addr), .msg_data_o(msg_data)
   );

   // ---------------- expected map, computed from the requirements ----------------
   function automatic logic [11:0] off_en(int d);  return d ? 12'h02C : 12'h00C; endfunction
   function automatic logic [11:0] off_db(int d);  return d ? 12'h030 : 12'h010; endfunction
   function automatic logic [11:0] off_st(int d);  return d ? 12'h0A0 : 12'h04C; endfunction
   function automatic logic [11:0] off_msk(int d); return d ? 12'h0A8 : 12'h054; endfunction
   function automatic logic [11:0] off_clr(int d); return d ? 12'h0AC : 12'h058; endfunction
   function automatic logic [11:0] off_dlo(int d); return d ? 12'h0CC : 12'h060; endfunction
   function automatic logic [11:0] off_alo(int d); return d ? 12'h0D4 : 12'h068; endfunction
   function automatic logic [11:0] off_dat(int d); return d ? 12'h0DC : 12'h070; endfunction
   function automatic int nch(int d); return d ? RD_N : WR_N; endfunction
   function automatic logic [63:0] exp_done_adr(int d);
      return {32'h0000_00D0 + 32'(d), 32'h1000_0000 + 32'(d) * 32'h100};
   endfunction
   function automatic logic [63:0] exp_abt_adr(int d);
      return {32'h0000_00A0 + 32'(d), 32'h2000_0000 + 32'(d) * 32'h100};
   endfunction
   function automatic logic [15:0] exp_val(int d, int c);
      return 16'hC000 + 16'(d) * 16'h100 + 16'(c) * 16'h11;
   endfunction

   function automatic logic busy_of(int d, int c);  return d ? rd_busy[c]  : wr_busy[c];  endfunction
   function automatic logic start_of(int d, int c); return d ? rd_start[c] : wr_start[c]; endfunction
   function automatic logic stop_of(int d, int c);  return d ? rd_stop[c]  : wr_stop[c];  endfunction

   // ---------------- helpers ----------------
   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [11:0] a, input logic [31:0] v);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [11:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic pulse(input int d, input bit is_abort, input int c);
      @(negedge clk);
      if (d == 0) begin
         if (is_abort) wr_abort[c] = 1'b1; else wr_done[c] = 1'b1;
      end else begin
         if (is_abort) rd_abort[c] = 1'b1; else rd_done[c] = 1'b1;
      end
      @(negedge clk);
      wr_done = '0; wr_abort = '0; rd_done = '0; rd_abort = '0;
   endtask

   task automatic take_msg(input string tag, input logic [63:0] ea, input logic [15:0] ed);
      int k;
      k = 0;
      while (!msg_req && k < 30) begin
         @(negedge clk);
         k++;
      end
      check({tag, " request seen"}, 64'(msg_req), 64'd1);
      check({tag, " address"}, msg_addr, ea);
      check({tag, " data"}, 64'(msg_data), 64'(ed));
      @(negedge clk);
      check({tag, " request held"}, 64'(msg_req), 64'd1);
      msg_ack = 1'b1;
      @(negedge clk);
      msg_ack = 1'b0;
      check({tag, " request dropped"}, 64'(msg_req), 64'd0);
   endtask

   task automatic no_msg(input string tag, input int cycles);
      bit seen;
      seen = 1'b0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (msg_req) seen = 1'b1;
      end
      check(tag, 64'(seen), 64'd0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      for (int d = 0; d < 2; d++) begin
         rd_reg(off_st(d), v);  check("R10 status after reset", 64'(v), 64'd0);
         rd_reg(off_msk(d), v); check("R10 mask after reset", 64'(v), 64'd0);
         rd_reg(off_en(d), v);  check("R10 enable after reset", 64'(v), 64'd0);
      end
      check("R10 busy after reset", 64'({rd_busy, wr_busy}), 64'd0);
      check("R10 no request after reset", 64'(msg_req), 64'd0);

      // R2: doorbell ignored while disabled
      for (int d = 0; d < 2; d++) begin
         wr_reg(off_db(d), 32'd0);
         check("R2 no start while disabled", 64'(start_of(d, 0)), 64'd0);
         check("R2 no busy while disabled", 64'(busy_of(d, 0)), 64'd0);
      end

      // program both directions
      for (int d = 0; d < 2; d++) begin
         wr_reg(off_en(d), 32'd1);
         wr_reg(off_dlo(d),     exp_done_adr(d)[31:0]);
         wr_reg(off_dlo(d) + 4, exp_done_adr(d)[63:32]);
         wr_reg(off_alo(d),     exp_abt_adr(d)[31:0]);
         wr_reg(off_alo(d) + 4, exp_abt_adr(d)[63:32]);
         for (int w = 0; w < (nch(d) + 1) / 2; w++)
            wr_reg(off_dat(d) + 12'(4 * w), {exp_val(d, 2*w+1), exp_val(d, 2*w)});
      end

      // R11: read back
      for (int d = 0; d < 2; d++) begin
         rd_reg(off_en(d), v);  check("R11 enable readback", 64'(v), 64'd1);
         rd_reg(off_dlo(d), v); check("R11 done address low", 64'(v), 64'(exp_done_adr(d)[31:0]));
         rd_reg(off_alo(d) + 4, v); check("R11 abort address high", 64'(v), 64'(exp_abt_adr(d)[63:32]));
         rd_reg(off_dat(d), v);
         check("R11 data word 0", 64'(v), 64'({exp_val(d, 1), exp_val(d, 0)}));
         rd_reg(off_db(d), v);  check("R11 doorbell reads zero", 64'(v), 64'd0);
         rd_reg(off_clr(d), v); check("R11 clear reads zero", 64'(v), 64'd0);
      end

      // sweep every channel of both directions
      for (int d = 0; d < 2; d++) begin
         for (int c = 0; c < nch(d); c++) begin
            // R3: start
            wr_reg(off_db(d), 32'(c));
            check("R3 start pulse", 64'(start_of(d, c)), 64'd1);
            check("R3 busy set", 64'(busy_of(d, c)), 64'd1);
            @(negedge clk);
            check("R3 start is one cycle", 64'(start_of(d, c)), 64'd0);
            wr_reg(off_db(d), 32'(c));
            check("R3 restart on busy ignored", 64'(start_of(d, c)), 64'd0);
            // R5: completion
            pulse(d, 1'b0, c);
            check("R5 done clears busy", 64'(busy_of(d, c)), 64'd0);
            rd_reg(off_st(d), v);
            check("R5 done status bit", 64'(v), 64'(32'd1 << c));
            // R8: message
            take_msg("R8 done message", exp_done_adr(d), exp_val(d, c));
            // R6: clear
            wr_reg(off_clr(d), 32'd1 << c);
            rd_reg(off_st(d), v);
            check("R6 clear done bit", 64'(v), 64'd0);
            // R4: stop a running channel
            wr_reg(off_db(d), 32'(c));
            wr_reg(off_db(d), STOP | 32'(c));
            check("R4 stop pulse", 64'(stop_of(d, c)), 64'd1);
            check("R4 stop clears busy", 64'(busy_of(d, c)), 64'd0);
            rd_reg(off_st(d), v);
            check("R4 abort status bit", 64'(v), 64'(32'd1 << (16 + c)));
            take_msg("R8 abort message", exp_abt_adr(d), exp_val(d, c));
            wr_reg(off_clr(d), 32'd0);
            rd_reg(off_st(d), v);
            check("R6 zero write keeps bit", 64'(v), 64'(32'd1 << (16 + c)));
            wr_reg(off_clr(d), 32'd1 << (16 + c));
            rd_reg(off_st(d), v);
            check("R6 clear abort bit", 64'(v), 64'd0);
            // R4: stop on idle channel
            wr_reg(off_db(d), STOP | 32'(c));
            check("R4 idle stop no pulse", 64'(stop_of(d, c)), 64'd0);
            rd_reg(off_st(d), v);
            check("R4 idle stop no status", 64'(v), 64'd0);
         end
      end

      // R1: channel numbers outside each direction's range
      for (int d = 0; d < 2; d++) begin
         for (int c = nch(d); c < 8; c++) begin
            wr_reg(off_db(d), 32'(c));
            check("R1 out-of-range start ignored", 64'({rd_start, wr_start, rd_busy, wr_busy}), 64'd0);
         end
         wr_reg(off_db(d), 32'h0000_00FF);
         check("R1 channel 255 ignored", 64'({rd_start, wr_start, rd_busy, wr_busy}), 64'd0);
      end

      // R5: abort input and stray pulses
      wr_reg(off_db(0), 32'd2);
      pulse(0, 1'b1, 2);
      check("R5 abort input clears busy", 64'(wr_busy[2]), 64'd0);
      rd_reg(off_st(0), v);
      check("R5 abort input status", 64'(v), 64'(32'd1 << 18));
      take_msg("R8 abort input message", exp_abt_adr(0), exp_val(0, 2));
      wr_reg(off_clr(0), 32'hFFFF_FFFF);
      pulse(1, 1'b0, 1);
      rd_reg(off_st(1), v);
      check("R5 done on idle channel ignored", 64'(v), 64'd0);
      no_msg("R5 idle done sends nothing", 6);

      // R7: masking
      wr_reg(off_msk(0), 32'h0000_0002);
      rd_reg(off_msk(0), v);
      check("R7 mask readback", 64'(v), 64'h2);
      wr_reg(off_db(0), 32'd1);
      pulse(0, 1'b0, 1);
      rd_reg(off_st(0), v);
      check("R7 masked status still sets", 64'(v), 64'h2);
      no_msg("R7 masked source silent", 10);
      wr_reg(off_clr(0), 32'h2);
      wr_reg(off_msk(0), 32'h0);

      // R8: event on already-set bit sends nothing
      wr_reg(off_db(1), 32'd0);
      pulse(1, 1'b0, 0);
      take_msg("R8 first done", exp_done_adr(1), exp_val(1, 0));
      wr_reg(off_db(1), 32'd0);
      pulse(1, 1'b0, 0);
      no_msg("R8 repeat on set bit silent", 8);
      wr_reg(off_clr(1), 32'hFFFF_FFFF);

      // R9: simultaneous events leave in fixed order
      wr_reg(off_db(0), 32'd3);
      wr_reg(off_db(0), 32'd0);
      wr_reg(off_db(1), 32'd1);
      wr_reg(off_db(1), 32'd0);
      @(negedge clk);
      wr_done[3] = 1'b1; wr_done[0] = 1'b1; rd_done[1] = 1'b1; rd_abort[0] = 1'b1;
      @(negedge clk);
      wr_done = '0; rd_done = '0; rd_abort = '0;
      take_msg("R9 first write ch0 done", exp_done_adr(0), exp_val(0, 0));
      take_msg("R9 second write ch3 done", exp_done_adr(0), exp_val(0, 3));
      take_msg("R9 third read ch1 done", exp_done_adr(1), exp_val(1, 1));
      take_msg("R9 fourth read ch0 abort", exp_abt_adr(1), exp_val(1, 0));
      no_msg("R9 nothing further", 6);

      finished = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule